// File: doc/BRIEF.md
# DMA Cache-Line Request Splitter

This block takes a single DMA transfer, described by a start byte address, a byte count and a direction, and turns it into a chain of memory requests. Each request stays inside one cache line. The first request begins at the raw start address and may sit at any offset within its line. Every later request begins on a line boundary. Only one line request is in flight at any time. The block waits for the memory side to answer each request, with an acknowledgement for a store or a data line for a load, before it issues the next request.

For a write transfer, the source presents the transfer bytes starting at the index the block reports. The block moves those bytes to their position in the line and marks them with byte enables. For a read transfer, each returned line is realigned so that the first valid byte lands at byte 0, and the bytes go out in order with byte enables. Completion is signalled in the cycle of the last response. In that same cycle the block stops reporting busy, so a new transfer can be loaded with no gap.

Top module: `dma_line_splitter`

## Requirements
- R1: Only one transfer is held at a time. A transfer offered while busy is not accepted and `xferFull` is high in that cycle. An idle block with a nonzero length accepts the transfer in the cycle it is offered.
- R2: A transfer of length 0 is refused with `xferBadLen` and leaves the block idle, with no request issued.
- R3: The first request has address equal to the start address. Its length equals the transfer length if (start mod LINE_BYTES) + length is at most LINE_BYTES. Otherwise its length is LINE_BYTES minus that offset.
- R4: Each later request has address start + bytes completed, and that address is a multiple of LINE_BYTES. Its length is the smaller of the remaining bytes and LINE_BYTES.
- R5: `reqValid` stays high with a stable address and length until `reqReady` is seen. After a handshake, no further request appears until a response has been received.
- R6: `reqStore` is 1 for a write transfer and 0 for a read transfer. `reqLineAddr` equals `reqAddr` with its low log2(LINE_BYTES) bits cleared.
- R7: `wrByteIdx` equals the number of bytes completed so far. Byte k of `wrData` goes out in byte lane (offset + k) for the first request and in lane k for later requests, where lane j is bits [8j+7:8j]. `reqByteEn` marks exactly those lanes.
- R8: For a read transfer, each response raises `rdValid` in the same cycle. `rdData` lane k holds the k-th valid byte of the line, counted from the start offset for the first chunk and from lane 0 for later chunks. `rdByteEn` has its low n bits set, where n is the chunk length.
- R9: `done` pulses in the cycle of the response to the final chunk. `busy` is low in that cycle, and a transfer offered in that cycle is accepted.
- R10: A response that arrives while no request is outstanding has no effect on any output except `errStray`, which is set and stays set until reset.
- R11: After reset, `busy`, `reqValid`, `done`, `rdValid` and `errStray` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xferValid | input | 1 | A transfer is offered |
| xferWrite | input | 1 | 1 = write transfer, 0 = read |
| xferAddr | input | ADDR_W | Start byte address |
| xferLen | input | LEN_W | Transfer length in bytes |
| xferAccept | output | 1 | Offered transfer is taken this cycle |
| xferFull | output | 1 | Offered transfer refused, block busy |
| xferBadLen | output | 1 | Offered transfer refused, zero length |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | Final chunk answered this cycle |
| wrData | input | LINE_BYTES*8 | Write bytes, lane 0 = transfer byte `wrByteIdx` |
| wrByteIdx | output | LEN_W | Bytes completed so far |
| reqValid | output | 1 | Line request valid |
| reqReady | input | 1 | Memory side takes the request |
| reqStore | output | 1 | 1 = store, 0 = load |
| reqAddr | output | ADDR_W | Full byte address of request |
| reqLineAddr | output | ADDR_W | Line-aligned address |
| reqLen | output | log2(LINE_BYTES)+1 | Request length in bytes |
| reqData | output | LINE_BYTES*8 | Store data placed in line lanes |
| reqByteEn | output | LINE_BYTES | Lanes carrying store data |
| rspValid | input | 1 | Response from memory side |
| rspIsData | input | 1 | 1 = data line, 0 = acknowledgement |
| rspData | input | LINE_BYTES*8 | Returned line |
| rdValid | output | 1 | Read bytes valid |
| rdData | output | LINE_BYTES*8 | Realigned read bytes |
| rdByteEn | output | LINE_BYTES | Valid read lanes |
| errStray | output | 1 | Sticky: response seen with nothing outstanding |

## Verification
Transfers are tried in both directions. The start offsets include aligned, mid-line and last-byte positions, and the lengths include one that exactly fills the rest of a line, one that crosses by a single byte, single bytes and multi-line spans. These cases separate the fits-in-line branch of the first-chunk length from the crossing branch, and they separate full middle chunks from a short tail. Random start points and lengths, with random ready and response delays, show that the request fields stay put while stalled and that nothing is issued while a response is pending. A write followed by a read of the same range checks lane placement end to end. A transfer chained into the completion cycle shows the zero-gap handover.

// File: rtl/dma_split_pkg.sv
package dma_split_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } splitState_e;

  typedef struct packed {
    logic load;    // capture a new transfer
    logic issued;  // request handshake completed
    logic retire;  // response for outstanding request
  } splitStrobe_t;
endpackage

// File: rtl/dma_split_ctrl.sv
module dma_split_ctrl
  import dma_split_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         xferValid,
  input  logic         lenZero,
  input  logic         reqReady,
  input  logic         rspValid,
  input  logic         allIssued,
  output splitStrobe_t strobe,
  output logic         reqValid,
  output logic         busy,
  output logic         done,
  output logic         xferAccept,
  output logic         xferFull,
  output logic         xferBadLen,
  output logic         errStray
);
  splitState_e state, stateNext;
  logic finish;

  always_comb begin
    reqValid      = (state == ST_ISSUE);
    strobe.issued = reqValid && reqReady;
    strobe.retire = (state == ST_WAIT) && rspValid;
    finish        = strobe.retire && allIssued;
    busy          = (state != ST_IDLE) && !finish;
    xferFull      = xferValid && busy;
    xferBadLen    = xferValid && !busy && lenZero;
    xferAccept    = xferValid && !busy && !lenZero;
    strobe.load   = xferAccept;
    done          = finish;
  end

  always_comb begin
    stateNext = state;
    if (strobe.load)        stateNext = ST_ISSUE;
    else if (finish)        stateNext = ST_IDLE;
    else if (strobe.retire) stateNext = ST_ISSUE;
    else if (strobe.issued) stateNext = ST_WAIT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      errStray <= 1'b0;
    end else begin
      state <= stateNext;
      if (rspValid && state != ST_WAIT) errStray <= 1'b1;
    end
  end
endmodule

// File: rtl/dma_split_path.sv
module dma_split_path
  import dma_split_pkg::*;
#(
  parameter int LINE_BYTES = 64,
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int CNT_W     = OFF_W + 1,
  localparam int DATA_W    = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  splitStrobe_t      strobe,
  input  logic              xferWrite,
  input  logic [ADDR_W-1:0] xferAddr,
  input  logic [LEN_W-1:0]  xferLen,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [ADDR_W-1:0] reqLineAddr,
  output logic [CNT_W-1:0]  reqLen,
  output logic              reqStore,
  output logic [DATA_W-1:0] reqData,
  output logic [LINE_BYTES-1:0] reqByteEn,
  output logic [DATA_W-1:0] rdData,
  output logic [LINE_BYTES-1:0] rdByteEn,
  output logic [LEN_W-1:0]  wrByteIdx,
  output logic              allIssued,
  output logic              firstChunk,
  output logic              lenZero
);
  logic [ADDR_W-1:0] startAddr;
  logic [LEN_W-1:0]  totalLen, bytesIssued, bytesDone, remain, rdChunk;
  logic              writeXfer;
  logic [OFF_W-1:0]  lineOff, shiftBytes;
  logic [LEN_W:0]    offPlusLen;

  always_comb begin
    lineOff    = startAddr[OFF_W-1:0];
    shiftBytes = firstChunk ? lineOff : '0;
    offPlusLen = {1'b0, totalLen} + (LEN_W+1)'(lineOff);
    remain     = totalLen - bytesDone;
    rdChunk    = bytesIssued - bytesDone;
    if (firstChunk) begin
      if (offPlusLen <= (LEN_W+1)'(LINE_BYTES)) reqLen = CNT_W'(totalLen);
      else reqLen = CNT_W'(LINE_BYTES) - CNT_W'(lineOff);
    end else if (remain < LEN_W'(LINE_BYTES)) begin
      reqLen = CNT_W'(remain);
    end else begin
      reqLen = CNT_W'(LINE_BYTES);
    end
    reqAddr     = startAddr + ADDR_W'(bytesDone);
    reqLineAddr = {reqAddr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    reqStore    = writeXfer;
    reqData     = wrData << {shiftBytes, 3'b000};
    rdData      = rspData >> {shiftBytes, 3'b000};
    for (int i = 0; i < LINE_BYTES; i++) begin
      reqByteEn[i] = (i >= int'(shiftBytes)) && (i < int'(shiftBytes) + int'(reqLen));
      rdByteEn[i]  = (i < int'(rdChunk));
    end
    wrByteIdx = bytesDone;
    allIssued = (bytesIssued == totalLen);
    lenZero   = (xferLen == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      startAddr   <= '0;
      totalLen    <= '0;
      bytesIssued <= '0;
      bytesDone   <= '0;
      writeXfer   <= 1'b0;
      firstChunk  <= 1'b0;
    end else if (strobe.load) begin
      startAddr   <= xferAddr;
      totalLen    <= xferLen;
      writeXfer   <= xferWrite;
      bytesIssued <= '0;
      bytesDone   <= '0;
      firstChunk  <= 1'b1;
    end else begin
      if (strobe.issued) bytesIssued <= bytesIssued + LEN_W'(reqLen);
      if (strobe.retire) begin
        bytesDone  <= bytesIssued;
        firstChunk <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dma_line_splitter.sv
module dma_line_splitter
  import dma_split_pkg::*;
#(
  parameter int LINE_BYTES = 64,
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int CNT_W     = OFF_W + 1,
  localparam int DATA_W    = LINE_BYTES * 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  xferValid,
  input  logic                  xferWrite,
  input  logic [ADDR_W-1:0]     xferAddr,
  input  logic [LEN_W-1:0]      xferLen,
  output logic                  xferAccept,
  output logic                  xferFull,
  output logic                  xferBadLen,
  output logic                  busy,
  output logic                  done,
  input  logic [DATA_W-1:0]     wrData,
  output logic [LEN_W-1:0]      wrByteIdx,
  output logic                  reqValid,
  input  logic                  reqReady,
  output logic                  reqStore,
  output logic [ADDR_W-1:0]     reqAddr,
  output logic [ADDR_W-1:0]     reqLineAddr,
  output logic [CNT_W-1:0]      reqLen,
  output logic [DATA_W-1:0]     reqData,
  output logic [LINE_BYTES-1:0] reqByteEn,
  input  logic                  rspValid,
  input  logic                  rspIsData,
  input  logic [DATA_W-1:0]     rspData,
  output logic                  rdValid,
  output logic [DATA_W-1:0]     rdData,
  output logic [LINE_BYTES-1:0] rdByteEn,
  output logic                  errStray
);
  splitStrobe_t strobe;
  logic allIssued, firstChunk, lenZero;

  dma_split_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .xferValid(xferValid), .lenZero(lenZero),
    .reqReady(reqReady), .rspValid(rspValid), .allIssued(allIssued),
    .strobe(strobe), .reqValid(reqValid), .busy(busy), .done(done),
    .xferAccept(xferAccept), .xferFull(xferFull), .xferBadLen(xferBadLen),
    .errStray(errStray)
  );

  dma_split_path #(.LINE_BYTES(LINE_BYTES), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_path (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .xferWrite(xferWrite),
    .xferAddr(xferAddr), .xferLen(xferLen), .wrData(wrData), .rspData(rspData),
    .reqAddr(reqAddr), .reqLineAddr(reqLineAddr), .reqLen(reqLen),
    .reqStore(reqStore), .reqData(reqData), .reqByteEn(reqByteEn),
    .rdData(rdData), .rdByteEn(rdByteEn), .wrByteIdx(wrByteIdx),
    .allIssued(allIssued), .firstChunk(firstChunk), .lenZero(lenZero)
  );

  assign rdValid = strobe.retire && rspIsData && !reqStore;
endmodule

// File: rtl/dma_split_checker.sv
module dma_split_checker #(
  parameter int LINE_BYTES = 64,
  parameter int ADDR_W     = 32,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int CNT_W     = OFF_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              xferValid,
  input logic              xferAccept,
  input logic              xferFull,
  input logic              busy,
  input logic              done,
  input logic              reqValid,
  input logic              reqReady,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [CNT_W-1:0]  reqLen,
  input logic              firstChunk,
  input logic              rdValid,
  input logic              errStray
);
  AST_BUSY_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    xferValid && busy |-> xferFull && !xferAccept); // R1
  AST_LEN_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |-> reqLen != '0 && (int'(reqAddr[OFF_W-1:0]) + int'(reqLen) <= LINE_BYTES)); // R3
  AST_LATER_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && !firstChunk |-> reqAddr[OFF_W-1:0] == '0); // R4
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && !reqReady |=> reqValid && $stable(reqAddr) && $stable(reqLen)); // R5
  AST_READ_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rdValid |-> !reqValid); // R8
  AST_DONE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !reqValid); // R9
  AST_STRAY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    errStray |=> errStray); // R10
endmodule

bind dma_line_splitter dma_split_checker #(.LINE_BYTES(LINE_BYTES), .ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .xferValid(xferValid), .xferAccept(xferAccept),
  .xferFull(xferFull), .busy(busy), .done(done), .reqValid(reqValid),
  .reqReady(reqReady), .reqAddr(reqAddr), .reqLen(reqLen),
  .firstChunk(firstChunk), .rdValid(rdValid), .errStray(errStray)
);

// File: tb/test_dma_line_splitter.sv
module test_dma_line_splitter;
  localparam int LB = 64;
  localparam int AW = 32;
  localparam int LW = 16;
  localparam int CW = $clog2(LB) + 1;
  localparam int DW = LB * 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic xferValid = 0, xferWrite = 0;
  logic [AW-1:0] xferAddr = '0;
  logic [LW-1:0] xferLen = '0;
  logic xferAccept, xferFull, xferBadLen, busy, done;
  logic [DW-1:0] wrData;
  logic [LW-1:0] wrByteIdx;
  logic reqValid, reqReady = 0, reqStore;
  logic [AW-1:0] reqAddr, reqLineAddr;
  logic [CW-1:0] reqLen;
  logic [DW-1:0] reqData;
  logic [LB-1:0] reqByteEn;
  logic rspValid = 0, rspIsData = 0;
  logic [DW-1:0] rspData = '0;
  logic rdValid;
  logic [DW-1:0] rdData;
  logic [LB-1:0] rdByteEn, errStray;

  int total = 0, bad = 0;
  bit preloaded = 0;
  logic [7:0] srcBuf [0:1023];
  logic [7:0] mem [0:4095];

  always #5 clk = ~clk;

  always_comb
    for (int i = 0; i < LB; i++) wrData[i*8 +: 8] = srcBuf[(int'(wrByteIdx) + i) & 1023];

  dma_line_splitter #(.LINE_BYTES(LB), .ADDR_W(AW), .LEN_W(LW)) i_dma_line_splitter (
    .clk(clk), .rst_n(rst_n), .xferValid(xferValid), .xferWrite(xferWrite),
    .xferAddr(xferAddr), .xferLen(xferLen), .xferAccept(xferAccept),
    .xferFull(xferFull), .xferBadLen(xferBadLen), .busy(busy), .done(done),
    .wrData(wrData), .wrByteIdx(wrByteIdx), .reqValid(reqValid),
    .reqReady(reqReady), .reqStore(reqStore), .reqAddr(reqAddr),
    .reqLineAddr(reqLineAddr), .reqLen(reqLen), .reqData(reqData),
    .reqByteEn(reqByteEn), .rspValid(rspValid), .rspIsData(rspIsData),
    .rspData(rspData), .rdValid(rdValid), .rdData(rdData),
    .rdByteEn(rdByteEn), .errStray(errStray[0])
  );
  assign errStray[LB-1:1] = '0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] lowMask(input int n);
    logic [63:0] m;
    for (int i = 0; i < 64; i++) m[i] = (i < n);
    return m;
  endfunction

  function automatic int firstLen(input int addr, input int len);
    int off = addr % LB;
    return (off + len <= LB) ? len : LB - off;
  endfunction

  task automatic runXfer(input bit wr, input int addr, input int len,
                         input bit chain, input bit nWr, input int nAddr, input int nLen);
    int doneB = 0, eLen, sh, off, badBytes, la;
    bit first = 1, last;
    off = addr % LB;
    if (wr) for (int i = 0; i < 1024; i++) srcBuf[i] = 8'($urandom);
    if (!preloaded) begin
      @(negedge clk);
      xferValid = 1; xferWrite = wr; xferAddr = AW'(addr); xferLen = LW'(len);
      #1 chk("R1 idle accept", 64'(xferAccept), 64'd1);
      @(negedge clk);
      xferValid = 0;
    end
    preloaded = 0;
    xferValid = 1; xferLen = 5;
    #1 chk("R1 busy full", 64'(xferFull), 64'd1);
    chk("R1 busy no accept", 64'(xferAccept), 64'd0);
    xferValid = 0;
    while (doneB < len) begin
      eLen = first ? firstLen(addr, len) : ((len - doneB < LB) ? len - doneB : LB);
      sh = first ? off : 0;
      repeat ($urandom % 3) begin
        chk("R5 valid held", 64'(reqValid), 64'd1);
        @(negedge clk);
      end
      reqReady = 1;
      #1 chk("R5 valid", 64'(reqValid), 64'd1);
      chk(first ? "R3 addr" : "R4 addr", 64'(reqAddr), 64'(addr + doneB));
      chk(first ? "R3 len" : "R4 len", 64'(reqLen), 64'(eLen));
      chk("R6 line addr", 64'(reqLineAddr), 64'(((addr + doneB) / LB) * LB));
      chk("R6 store", 64'(reqStore), 64'(wr));
      chk("R7 byte idx", 64'(wrByteIdx), 64'(doneB));
      chk("R7 byte enables", 64'(reqByteEn), lowMask(eLen) << sh);
      if (wr) begin
        badBytes = 0;
        for (int k = 0; k < eLen; k++) begin
          if (reqData[(sh + k)*8 +: 8] !== srcBuf[doneB + k]) badBytes++;
          mem[addr + doneB + k] = srcBuf[doneB + k];
        end
        chk("R7 write lanes", 64'(badBytes), 64'd0);
      end
      @(negedge clk);
      reqReady = 0;
      repeat ($urandom % 3 + 1) begin
        chk("R5 no req while waiting", 64'(reqValid), 64'd0);
        @(negedge clk);
      end
      la = ((addr + doneB) / LB) * LB;
      for (int i = 0; i < LB; i++) rspData[i*8 +: 8] = mem[la + i];
      rspValid = 1; rspIsData = !wr;
      last = (doneB + eLen == len);
      if (last && chain) begin
        xferValid = 1; xferWrite = nWr; xferAddr = AW'(nAddr); xferLen = LW'(nLen);
      end
      #1 chk("R8 rd valid", 64'(rdValid), 64'(!wr));
      if (!wr) begin
        chk("R8 rd enables", 64'(rdByteEn), lowMask(eLen));
        badBytes = 0;
        for (int k = 0; k < eLen; k++)
          if (rdData[k*8 +: 8] !== mem[addr + doneB + k]) badBytes++;
        chk("R8 rd lanes", 64'(badBytes), 64'd0);
      end
      chk("R9 done", 64'(done), 64'(last));
      if (last) chk("R9 busy low", 64'(busy), 64'd0);
      if (last && chain) chk("R9 same-cycle accept", 64'(xferAccept), 64'd1);
      @(negedge clk);
      rspValid = 0; xferValid = 0;
      if (last && chain) preloaded = 1;
      doneB += eLen;
      first = 0;
    end
    if (!chain) chk("R9 idle after", 64'(busy), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int a, l;
    void'($urandom(32'd4242));
    for (int i = 0; i < 4096; i++) mem[i] = 8'($urandom);
    for (int i = 0; i < 1024; i++) srcBuf[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk("R11 busy", 64'(busy), 0); chk("R11 reqValid", 64'(reqValid), 0);
    chk("R11 done", 64'(done), 0); chk("R11 rdValid", 64'(rdValid), 0);
    chk("R11 errStray", 64'(errStray[0]), 0);
    rst_n = 1;
    @(negedge clk);
    // R2 zero length
    xferValid = 1; xferLen = 0; xferAddr = 100;
    #1 chk("R2 bad len", 64'(xferBadLen), 1); chk("R2 no accept", 64'(xferAccept), 0);
    @(negedge clk); xferValid = 0;
    chk("R2 still idle", 64'(busy), 0); chk("R2 no request", 64'(reqValid), 0);
    // directed corners
    runXfer(0, 128, 64, 0, 0, 0, 0);
    runXfer(0, 191, 1, 0, 0, 0, 0);
    runXfer(1, 316, 4, 0, 0, 0, 0);
    runXfer(1, 380, 5, 0, 0, 0, 0);
    runXfer(0, 380, 5, 0, 0, 0, 0);
    runXfer(1, 512, 128, 0, 0, 0, 0);
    runXfer(0, 512, 128, 0, 0, 0, 0);
    runXfer(1, 657, 300, 0, 0, 0, 0);
    runXfer(0, 650, 320, 0, 0, 0, 0);
    // R9 chained handover: read then write loaded in completion cycle
    runXfer(0, 1000, 70, 1, 1, 2001, 90);
    runXfer(1, 2001, 90, 0, 0, 0, 0);
    runXfer(0, 2001, 90, 0, 0, 0, 0);
    // random mix
    for (int n = 0; n < 25; n++) begin
      a = $urandom % 3500;
      l = $urandom % 400 + 1;
      runXfer(1'($urandom), a, l, 0, 0, 0, 0);
    end
    // R10 stray response while idle
    @(negedge clk);
    rspValid = 1; rspIsData = 1;
    #1 chk("R10 no rd on stray", 64'(rdValid), 0); chk("R10 no done", 64'(done), 0);
    @(negedge clk); rspValid = 0;
    chk("R10 sticky set", 64'(errStray[0]), 1); chk("R10 stays idle", 64'(busy), 0);
    chk("R10 no request", 64'(reqValid), 0);
    repeat (3) @(negedge clk);
    chk("R10 still set", 64'(errStray[0]), 1);
    rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    chk("R11 cleared", 64'(errStray[0]), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule